// File: doc/BRIEF.md
# PHY Status-Change Interrupt Controller

This block turns changes on four PHY status signals into one active-low interrupt request. The four signals are auto-negotiation done, speed, duplex and link. Speed, duplex and link are level signals, and any change in their level counts as an event. Auto-negotiation done counts as an event only when it rises. Each event sets a sticky bit in a status register. A per-source mask bit decides whether a set status bit may drive the pin. A global enable bit gates the pin as a whole.

Software reaches the block through a plain 16-bit register port. The control register sits at address 18 and holds the global enable and the four mask bits. The status register sits at address 19. Reading the status register returns its contents and clears them on the same clock edge. The serial management transport that carries these accesses is not part of this block. Neither is the logic that produces the status signals.

Top module: `phy_irq_ctrl`

## Requirements
- R1: After a reset with `rst_n` low, `irq_n` is high and reads of address 18 and of address 19 both return 0.
- R2: A write to address 18 stores the global enable from data bit 1 and the mask bits from data bits 7:4. Bit 4 is auto-negotiation, bit 5 speed, bit 6 duplex and bit 7 link. A read of address 18 returns these bits in the same positions and 0 in every other bit.
- R3: A rise or a fall on `phy_speed`, `phy_duplex` or `phy_link` sets status bit 5, 6 or 7 of address 19. The bit is set at the clock edge that first samples the new level.
- R4: A rise on `phy_an_done` sets status bit 4. A fall on `phy_an_done` sets no status bit.
- R5: A status bit stays set through any number of cycles until address 19 is read.
- R6: A read of address 19 returns the status in bits 7:4 and 0 in every other bit, and it clears the status at that clock edge. An event sampled at the same edge as the clearing read is kept set.
- R7: A source whose mask bit is 0 still sets its status bit, but it cannot pull `irq_n` low.
- R8: While the global enable bit is 0, `irq_n` stays high whatever the status and masks hold.
- R9: `irq_n` is low exactly when the global enable is 1 and some status bit is set with its mask bit 1. The pin follows the registers without an added cycle of delay.
- R10: Writes to address 19 and to any address other than 18 change no state. A read of any address other than 18 or 19 returns 0 and clears nothing.
- R11: Status levels that are present while reset is held do not produce events once reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| phy_an_done | input | 1 | Auto-negotiation complete level |
| phy_speed | input | 1 | Speed status level |
| phy_duplex | input | 1 | Duplex status level |
| phy_link | input | 1 | Link status level |
| reg_addr | input | 5 | Register address |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_rd | input | 1 | Read strobe, one cycle; clears status when the address is 19 |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The bench builds the block with its default parameters: control at 18, status at 19, global enable at bit 1 and the four-bit mask field at bits 7:4. With only four sources, the full space is small enough to sweep completely. The first sweep covers every mask value against every single source, with the global enable both on and off. The second covers every mask value against every non-empty combination of simultaneous events. Expected pin levels and status words are computed arithmetically from the mask and the event pattern. Directed cases cover the remaining corners: a clearing read in the same cycle as a new event, a falling auto-negotiation level, and levels present during reset.

// File: rtl/phy_irq_pkg.sv
// Package: shared constants and types of the PHY interrupt controller.
// Assumes the source order auto-negotiation, speed, duplex, link (index 0..3).
package phy_irq_pkg;
    localparam int NUM_SRC = 4;
    // Source indices inside every per-source vector
    localparam int SRC_AN     = 0;
    localparam int SRC_SPEED  = 1;
    localparam int SRC_DUPLEX = 2;
    localparam int SRC_LINK   = 3;
    // Sources detected on a rising edge only; the rest on any change
    localparam logic [NUM_SRC-1:0] RISE_ONLY = 4'b0001;
    typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/phy_irq_detect.sv
// Module: per-source event detector.
// Compares each status input with its value at the previous edge. The
// previous-value registers follow the inputs during reset too, so levels
// present at reset release never look like events.
// Assumes the status inputs are already synchronous to clk.
module phy_irq_detect
    import phy_irq_pkg::*;
#(
    parameter int N = NUM_SRC,
    parameter logic [N-1:0] RISE_MASK = RISE_ONLY
) (
    input  logic         clk,
    input  logic [N-1:0] level_in,
    output logic [N-1:0] event_out
);
    logic [N-1:0] level_q;

    // Track the previous level of every input, reset or not
    always_ff @(posedge clk) begin
        level_q <= level_in;
    end

    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_src
            if (RISE_MASK[gi]) begin : g_rise
                // Rising edge only
                assign event_out[gi] = level_in[gi] & ~level_q[gi];
            end else begin : g_any
                // Any change of level
                assign event_out[gi] = level_in[gi] ^ level_q[gi];
            end
        end
    endgenerate
endmodule

// File: rtl/phy_irq_status.sv
// Module: sticky status register.
// Sets a bit for every event. Clears all bits on a clearing read. An event
// sampled at the clearing edge survives the clear.
module phy_irq_status
    import phy_irq_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] event_in,
    input  logic         clr,
    output logic [N-1:0] status
);
    // Accumulate events; a clearing read drops old bits only
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (clr ? '0 : status) | event_in;
    end

    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_chk
            AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
                event_in[gi] |=> status[gi]);                               // R3
            AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
                (status[gi] && !clr) |=> status[gi]);                       // R5
            AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
                (!status[gi] && !event_in[gi]) |=> !status[gi]);            // R11
            AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
                (clr && !event_in[gi]) |=> !status[gi]);                    // R6
        end
    endgenerate
endmodule

// File: rtl/phy_irq_regs.sv
// Module: register file for the control word and the status read-back.
// Decodes writes into the control register, multiplexes read data and
// raises a clear strobe on a read of the status address.
// Assumes one-cycle write and read strobes; read data is combinational.
module phy_irq_regs
    import phy_irq_pkg::*;
#(
    parameter int N         = NUM_SRC,
    parameter int ADDR_W    = 5,
    parameter int DATA_W    = 16,
    parameter int CTRL_ADDR = 18,
    parameter int STAT_ADDR = 19,
    parameter int GEN_BIT   = 1,
    parameter int FIELD_LSB = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [DATA_W-1:0] wdata,
    input  logic [N-1:0]      status,
    output logic [DATA_W-1:0] rdata,
    output logic              gen_en,
    output logic [N-1:0]      mask,
    output logic              clr
);
    localparam int FIELD_MSB = FIELD_LSB + N - 1;
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);

    logic ctrl_wr;
    assign ctrl_wr = wr && (addr == CTRL_A);
    assign clr     = rd && (addr == STAT_A);

    // Control register: global enable and per-source masks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gen_en <= 1'b0;
            mask   <= '0;
        end else if (ctrl_wr) begin
            gen_en <= wdata[GEN_BIT];
            mask   <= wdata[FIELD_MSB:FIELD_LSB];
        end
    end

    // Read multiplexer; unmapped bits and addresses read as zero
    always_comb begin
        rdata = '0;
        if (addr == CTRL_A) begin
            rdata[GEN_BIT]             = gen_en;
            rdata[FIELD_MSB:FIELD_LSB] = mask;
        end else if (addr == STAT_A) begin
            rdata[FIELD_MSB:FIELD_LSB] = status;
        end
    end

    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && addr == CTRL_A) |=> ($stable(mask) && $stable(gen_en)));   // R10
    AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == CTRL_A) |=> (mask == $past(wdata[FIELD_MSB:FIELD_LSB])
                                     && gen_en == $past(wdata[GEN_BIT])));  // R2
endmodule

// File: rtl/phy_irq_ctrl.sv
// Module: top of the PHY status-change interrupt controller.
// Wires the detector, the sticky status and the register file together and
// forms the active-low request from the enable, mask and status registers.
// Assumes synchronous status inputs and a synchronous active-low reset.
module phy_irq_ctrl
    import phy_irq_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int DATA_W    = 16,
    parameter int CTRL_ADDR = 18,
    parameter int STAT_ADDR = 19,
    parameter int GEN_BIT   = 1,
    parameter int FIELD_LSB = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phy_an_done,
    input  logic              phy_speed,
    input  logic              phy_duplex,
    input  logic              phy_link,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_n
);
    src_vec_t levels, events, status, mask;
    logic     gen_en, clr;

    // Pack the status inputs in source order
    always_comb begin
        levels             = '0;
        levels[SRC_AN]     = phy_an_done;
        levels[SRC_SPEED]  = phy_speed;
        levels[SRC_DUPLEX] = phy_duplex;
        levels[SRC_LINK]   = phy_link;
    end

    phy_irq_detect #(.N(NUM_SRC), .RISE_MASK(RISE_ONLY)) u_detect (
        .clk       (clk),
        .level_in  (levels),
        .event_out (events)
    );

    phy_irq_status #(.N(NUM_SRC)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .event_in (events),
        .clr      (clr),
        .status   (status)
    );

    phy_irq_regs #(
        .N(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR),
        .STAT_ADDR(STAT_ADDR), .GEN_BIT(GEN_BIT), .FIELD_LSB(FIELD_LSB)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (reg_addr),
        .wr     (reg_wr),
        .rd     (reg_rd),
        .wdata  (reg_wdata),
        .status (status),
        .rdata  (reg_rdata),
        .gen_en (gen_en),
        .mask   (mask),
        .clr    (clr)
    );

    // Request low while enabled and any unmasked status bit is set
    always_comb begin
        irq_n = ~(gen_en & (|(status & mask)));
    end

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> irq_n);                                                  // R1
    AST_IRQ_NEEDS_GEN: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> gen_en);                                                 // R8
    AST_IRQ_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (status != '0));                                         // R7
endmodule

// File: tb/tb_phy_irq_ctrl.sv
module tb_phy_irq_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        phy_an_done = 1'b0, phy_speed = 1'b0, phy_duplex = 1'b0, phy_link = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq_n;

    int n_checks = 0;
    int n_errors = 0;
    logic [3:0] cur = '0;   // bench copy of input levels: an, speed, duplex, link

    phy_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .phy_an_done(phy_an_done), .phy_speed(phy_speed),
        .phy_duplex(phy_duplex), .phy_link(phy_link),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_n(irq_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic drive_levels(input logic [3:0] v);
        @(negedge clk);
        cur = v;
        phy_an_done = v[0]; phy_speed = v[1]; phy_duplex = v[2]; phy_link = v[3];
        @(negedge clk);
        #1;
    endtask

    task automatic reg_write(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        #1;
    endtask

    task automatic reg_read(input logic [4:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
        #1;
    endtask

    // Event pattern p: bit0 fires a rise on an_done, bits 3:1 flip levels
    function automatic logic [3:0] fire(input logic [3:0] base, input logic [3:0] p);
        logic [3:0] r;
        r = base ^ {p[3:1], 1'b0};
        if (p[0]) r[0] = 1'b1;
        return r;
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_errors++; n_checks++;
        $display("FAIL watchdog: got hang expected completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin : stim
        logic [15:0] rd;
        // R11: levels held during reset must not become events
        phy_speed = 1'b1; phy_duplex = 1'b1; phy_link = 1'b1; cur = 4'b1110;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        check("R1 irq_n after reset", {15'd0, irq_n}, 16'd1);
        reg_read(5'd18, rd); check("R1 ctrl after reset", rd, 16'h0000);
        reg_read(5'd19, rd); check("R11 no event from reset levels", rd, 16'h0000);

        // R2: writable bits only
        reg_write(5'd18, 16'hFFFF);
        reg_read(5'd18, rd); check("R2 ctrl readback", rd, 16'h00F2);
        // R10: writes elsewhere ignored, reads elsewhere zero
        reg_write(5'd19, 16'hFFFF);
        reg_read(5'd19, rd); check("R10 status write ignored", rd, 16'h0000);
        reg_write(5'd7, 16'h0000);
        reg_read(5'd18, rd); check("R10 other write ignored", rd, 16'h00F2);
        reg_read(5'd7, rd);  check("R10 other read zero", rd, 16'h0000);
        check("R10 irq_n idle", {15'd0, irq_n}, 16'd1);

        // R5: sticky across many cycles
        drive_levels(cur ^ 4'b1000);
        repeat (6) @(negedge clk);
        #1;
        check("R5 irq_n held low", {15'd0, irq_n}, 16'd0);
        reg_read(5'd7, rd);
        check("R10 other read does not clear", {15'd0, irq_n}, 16'd0);
        reg_read(5'd19, rd); check("R5 sticky link", rd, 16'h0080);
        check("R6 irq_n after clear", {15'd0, irq_n}, 16'd1);

        // R6: event in the same cycle as the clearing read survives
        drive_levels(cur ^ 4'b0100);
        @(negedge clk);
        reg_addr = 5'd19; reg_rd = 1'b1;
        cur = cur ^ 4'b1000; phy_link = cur[3];
        #1 rd = reg_rdata;
        check("R6 read returns old status", rd, 16'h0040);
        @(negedge clk);
        reg_rd = 1'b0;
        #1;
        reg_read(5'd19, rd); check("R6 concurrent event kept", rd, 16'h0080);

        // Sweep 1: every global enable, every mask, every single source (R3 R4 R7 R8 R9)
        for (int g = 0; g < 2; g++) begin
            for (int m = 0; m < 16; m++) begin
                for (int s = 0; s < 4; s++) begin
                    logic [3:0] p;
                    p = 4'(1 << s);
                    reg_write(5'd18, {8'd0, 4'(m), 2'b00, 1'(g), 1'b0});
                    drive_levels(fire(cur, p));
                    check("R9 R7 R8 single source irq_n", {15'd0, irq_n},
                          {15'd0, ~(1'(g) & (|(p & 4'(m))))});
                    reg_read(5'd19, rd);
                    check("R3 R4 single source status", rd, {8'd0, p, 4'd0});
                    if (s == 0) begin
                        drive_levels(cur & 4'b1110);
                        reg_read(5'd19, rd);
                        check("R4 falling an_done ignored", rd, 16'h0000);
                    end
                    check("R6 irq_n released", {15'd0, irq_n}, 16'd1);
                end
            end
        end

        // Sweep 2: enabled, every mask, every simultaneous event pattern (R9)
        for (int m = 0; m < 16; m++) begin
            for (int q = 1; q < 16; q++) begin
                logic [3:0] p;
                p = 4'(q);
                reg_write(5'd18, {8'd0, 4'(m), 4'b0010});
                drive_levels(fire(cur, p));
                check("R9 pattern irq_n", {15'd0, irq_n}, {15'd0, ~(|(p & 4'(m)))});
                reg_read(5'd19, rd);
                check("R3 R6 pattern status", rd, {8'd0, p, 4'd0});
                if (cur[0]) begin
                    drive_levels(cur & 4'b1110);
                    reg_read(5'd19, rd);
                end
            end
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule